// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller with Bus Traffic Meter

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared snooping bus. It uses four line states: Invalid, Shared, Exclusive and Modified. On the processor side it takes single-word loads and stores under a request/ready handshake. On the bus side it asks for the bus, then issues a read, a read-for-ownership, or a write-back of a dirty victim. In the same cycle it also watches the transactions its peers make and reacts to them. A wired-OR shared line answers each fill, and the controller uses it to pick Exclusive or Shared for the new line. A store that hits an Exclusive line moves it to Modified without touching the bus.

When a snoop hits, the controller drives its hit and shared lines. A dirty copy is flushed. The controller supplies the line only when no lower-numbered cache also hit, so at most one cache drives data. A saturating meter adds up the bytes that each bus transaction of this cache costs: a fixed control overhead plus one line of data. This lets the bandwidth of workloads be compared. The memory responder, the arbiter and the peer caches sit outside the block.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready_o`, `bus_req_o` and `bus_bytes_o` are zero, and no snoop hits.
- R2: A load miss raises `bus_req_o` with command 0 (read) and the full request address. At the grant, the line fills with `bus_rdata_i` and enters Shared if `bus_shared_i` is high, Exclusive otherwise. `cpu_ready_o` then pulses in the next cycle with the fill data on `cpu_rdata_o`.
- R3: A load that hits in S, E or M, and a store that hits in E or M, complete with no bus request. `cpu_ready_o` is high in the cycle after the request is accepted. A store to Exclusive leaves the line Modified.
- R4: A store that hits in Shared, or misses, issues command 1 (read-for-ownership) at the request address. At the grant the line becomes Modified and holds the store data.
- R5: A miss to a set whose line is Modified under another tag first issues command 2 (write-back) with the victim address and data, then the fill. A clean victim is dropped silently. If the victim stops being dirty while the request waits, the write-back is skipped.
- R6: A snooped read (command 0) that hits raises `snoop_hit_o` and `snoop_shared_o` in the same cycle. An E or M line becomes Shared, and an M line raises `flush_o`.
- R7: A snooped read-for-ownership (1) or address-only upgrade (3) that hits invalidates the line, and an M line raises `flush_o` on command 1. A snooped write-back (2) changes nothing.
- R8: On a snooped command 0 or 1 that hits, `supply_o` is high, with the line on `snoop_data_o`, only when no bit of `peer_hit_i` below index `CACHE_ID` is set. Bits at or above `CACHE_ID` have no effect.
- R9: `bus_bytes_o` adds CTRL_BYTES+LINE_BYTES (70) for each own granted transaction and for each flush. It saturates at all ones. `cnt_clr_i` clears it at the next edge, with priority over any increment.
- R10: In a cycle with `snoop_valid_i` high, a processor request is not accepted. It is accepted in the first cycle after the snoop ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Word address: low bits index, high bits tag |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Load data, valid with ready |
| bus_req_o | output | 1 | Bus request, held until grant |
| bus_cmd_o | output | 2 | 0 read, 1 read-for-ownership, 2 write-back |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_gnt_i | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata_i | input | DATA_W | Fill data, sampled at grant |
| bus_shared_i | input | 1 | Wired-OR shared line, sampled at grant |
| snoop_valid_i | input | 1 | A peer transaction is on the bus |
| snoop_cmd_i | input | 2 | Peer command: 0 read, 1 read-for-ownership, 2 write-back, 3 upgrade |
| snoop_addr_i | input | ADDR_W | Peer transaction address |
| peer_hit_i | input | NUM_CACHES | Hit lines of all caches, indexed by cache number |
| snoop_hit_o | output | 1 | This cache holds the snooped line |
| snoop_shared_o | output | 1 | Drive onto the shared line |
| supply_o | output | 1 | This cache supplies the snooped line |
| flush_o | output | 1 | Dirty copy is written back on this snoop |
| snoop_data_o | output | DATA_W | Snooped line data |
| cnt_clr_i | input | 1 | Synchronous clear of the byte meter |
| bus_bytes_o | output | CNT_W | Saturating bus byte total |

## Verification
The hardest case to reach is a snoop that lands while this controller is still waiting for the bus. In that case the pending command has to be recomputed from the new line state. The bench steers a store miss onto a set with a dirty victim and holds back the grant. While the write-back is pending, it injects a peer read-for-ownership to the victim. It then checks the flush, the skipped write-back, and the read-for-ownership that follows. Seeded random mixes of loads, stores and peer snoops over a few tags per set reach the remaining state pairs. They also drive the meter into saturation, and a reference model tracks every line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_e;
  typedef enum logic [1:0] {CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_WB = 2'd2, CMD_UPG = 2'd3} bus_cmd_e;
  typedef enum logic [1:0] {PS_IDLE = 2'd0, PS_BUS = 2'd1, PS_RESP = 2'd2} proc_st_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [$clog2(SETS)-1:0]  a_idx_i,
  output line_st_e                 a_st_o,
  output logic [TAG_W-1:0]         a_tag_o,
  output logic [DATA_W-1:0]        a_data_o,
  input  logic [$clog2(SETS)-1:0]  b_idx_i,
  output line_st_e                 b_st_o,
  output logic [TAG_W-1:0]         b_tag_o,
  output logic [DATA_W-1:0]        b_data_o,
  input  logic                     wr_en_i,
  input  logic [$clog2(SETS)-1:0]  wr_idx_i,
  input  line_st_e                 wr_st_i,
  input  logic [TAG_W-1:0]         wr_tag_i,
  input  logic [DATA_W-1:0]        wr_data_i
);
  line_st_e            st_q   [SETS];
  logic [TAG_W-1:0]    tag_q  [SETS];
  logic [DATA_W-1:0]   data_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= ST_I;
    end else if (wr_en_i) begin
      st_q[wr_idx_i] <= wr_st_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign a_st_o   = st_q[a_idx_i];
  assign a_tag_o  = tag_q[a_idx_i];
  assign a_data_o = data_q[a_idx_i];
  assign b_st_o   = st_q[b_idx_i];
  assign b_tag_o  = tag_q[b_idx_i];
  assign b_data_o = data_q[b_idx_i];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int CACHE_ID   = 0,
  parameter int TAG_W      = 13
) (
  input  logic                  valid_i,
  input  bus_cmd_e              cmd_i,
  input  logic [TAG_W-1:0]      tag_i,
  input  line_st_e              line_st_i,
  input  logic [TAG_W-1:0]      line_tag_i,
  input  logic [NUM_CACHES-1:0] peer_hit_i,
  output logic                  hit_o,
  output logic                  shared_o,
  output logic                  supply_o,
  output logic                  flush_o,
  output logic                  upd_o,
  output line_st_e              nxt_st_o
);
  logic [NUM_CACHES-1:0] lower_mask;
  logic                  lower_hit;

  for (genvar j = 0; j < NUM_CACHES; j++) begin : g_mask
    assign lower_mask[j] = (j < CACHE_ID);
  end

  assign lower_hit = |(peer_hit_i & lower_mask);
  assign hit_o     = valid_i && (line_st_i != ST_I) && (line_tag_i == tag_i);

  always_comb begin
    shared_o = 1'b0;
    supply_o = 1'b0;
    flush_o  = 1'b0;
    upd_o    = 1'b0;
    nxt_st_o = line_st_i;
    unique case (cmd_i)
      CMD_RD: begin
        shared_o = hit_o;
        supply_o = hit_o && !lower_hit;
        flush_o  = hit_o && (line_st_i == ST_M);
        upd_o    = hit_o && (line_st_i != ST_S);
        nxt_st_o = ST_S;
      end
      CMD_RDX: begin
        supply_o = hit_o && !lower_hit;
        flush_o  = hit_o && (line_st_i == ST_M);
        upd_o    = hit_o;
        nxt_st_o = ST_I;
      end
      CMD_UPG: begin
        upd_o    = hit_o;
        nxt_st_o = ST_I;
      end
      default: ;  // peer write-back: nothing to do
    endcase
  end
endmodule

// File: rtl/mesi_traffic_counter.sv
module mesi_traffic_counter
  import mesi_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int CTRL_BYTES = 6,
  parameter int LINE_BYTES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             own_valid_i,
  input  bus_cmd_e         own_cmd_i,
  input  logic             flush_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W:0] FULL_COST = (CNT_W+1)'(CTRL_BYTES + LINE_BYTES);
  localparam logic [CNT_W:0] ADDR_COST = (CNT_W+1)'(CTRL_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   own_inc, flush_inc, sum;

  assign own_inc   = !own_valid_i ? '0 : (own_cmd_i == CMD_UPG) ? ADDR_COST : FULL_COST;
  assign flush_inc = flush_i ? FULL_COST : '0;
  assign sum       = {1'b0, cnt_q} + own_inc + flush_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (sum[CNT_W]) cnt_q <= '1;
    else               cnt_q <= sum[CNT_W-1:0];
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int SETS       = 8,
  parameter int NUM_CACHES = 4,
  parameter int CACHE_ID   = 0,
  parameter int CNT_W      = 32,
  parameter int CTRL_BYTES = 6,
  parameter int LINE_BYTES = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_req_i,
  input  logic                  cpu_we_i,
  input  logic [ADDR_W-1:0]     cpu_addr_i,
  input  logic [DATA_W-1:0]     cpu_wdata_i,
  output logic                  cpu_ready_o,
  output logic [DATA_W-1:0]     cpu_rdata_o,
  output logic                  bus_req_o,
  output logic [1:0]            bus_cmd_o,
  output logic [ADDR_W-1:0]     bus_addr_o,
  output logic [DATA_W-1:0]     bus_wdata_o,
  input  logic                  bus_gnt_i,
  input  logic [DATA_W-1:0]     bus_rdata_i,
  input  logic                  bus_shared_i,
  input  logic                  snoop_valid_i,
  input  logic [1:0]            snoop_cmd_i,
  input  logic [ADDR_W-1:0]     snoop_addr_i,
  input  logic [NUM_CACHES-1:0] peer_hit_i,
  output logic                  snoop_hit_o,
  output logic                  snoop_shared_o,
  output logic                  supply_o,
  output logic                  flush_o,
  output logic [DATA_W-1:0]     snoop_data_o,
  input  logic                  cnt_clr_i,
  output logic [CNT_W-1:0]      bus_bytes_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx, wr_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag, a_tag, b_tag, wr_tag;
  logic [DATA_W-1:0] a_data, b_data, wr_data, rdata_q;
  line_st_e          a_st, b_st, wr_st, snp_nxt;
  logic              wr_en, snp_upd;
  proc_st_e          ps_q, ps_d;
  bus_cmd_e          own_cmd;
  logic              cpu_hit, local_ok, victim_dirty, accept, own_grant, fill_done;

  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snoop_addr_i[IDX_W-1:0];
  assign snp_tag = snoop_addr_i[ADDR_W-1:IDX_W];

  mesi_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
    .clk_i, .rst_ni,
    .a_idx_i(cpu_idx), .a_st_o(a_st), .a_tag_o(a_tag), .a_data_o(a_data),
    .b_idx_i(snp_idx), .b_st_o(b_st), .b_tag_o(b_tag), .b_data_o(b_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_st_i(wr_st), .wr_tag_i(wr_tag), .wr_data_i(wr_data)
  );

  mesi_snoop_unit #(.NUM_CACHES(NUM_CACHES), .CACHE_ID(CACHE_ID), .TAG_W(TAG_W)) snoop_i (
    .valid_i(snoop_valid_i), .cmd_i(bus_cmd_e'(snoop_cmd_i)), .tag_i(snp_tag),
    .line_st_i(b_st), .line_tag_i(b_tag), .peer_hit_i,
    .hit_o(snoop_hit_o), .shared_o(snoop_shared_o), .supply_o, .flush_o,
    .upd_o(snp_upd), .nxt_st_o(snp_nxt)
  );

  assign snoop_data_o = b_data;

  // Processor side
  assign cpu_hit      = (a_st != ST_I) && (a_tag == cpu_tag);
  assign local_ok     = cpu_hit && (!cpu_we_i || a_st == ST_E || a_st == ST_M);
  assign victim_dirty = (a_st == ST_M) && (a_tag != cpu_tag);
  assign accept       = (ps_q == PS_IDLE) && cpu_req_i && !snoop_valid_i;

  // command re-derived every cycle so snoops during the wait are honoured
  assign own_cmd   = victim_dirty ? CMD_WB : (cpu_we_i ? CMD_RDX : CMD_RD);
  assign bus_req_o = (ps_q == PS_BUS);
  assign bus_cmd_o = own_cmd;
  assign bus_addr_o  = victim_dirty ? {a_tag, cpu_idx} : cpu_addr_i;
  assign bus_wdata_o = a_data;
  assign own_grant   = bus_req_o && bus_gnt_i;
  assign fill_done   = own_grant && (own_cmd != CMD_WB);

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = cpu_idx;
    wr_st   = ST_I;
    wr_tag  = a_tag;
    wr_data = a_data;
    if (snp_upd) begin
      wr_en   = 1'b1;
      wr_idx  = snp_idx;
      wr_st   = snp_nxt;
      wr_tag  = b_tag;
      wr_data = b_data;
    end else if (own_grant) begin
      wr_en = 1'b1;
      unique case (own_cmd)
        CMD_WB: wr_st = ST_I;
        CMD_RD: begin
          wr_st   = bus_shared_i ? ST_S : ST_E;
          wr_tag  = cpu_tag;
          wr_data = bus_rdata_i;
        end
        default: begin
          wr_st   = ST_M;
          wr_tag  = cpu_tag;
          wr_data = cpu_wdata_i;
        end
      endcase
    end else if (accept && local_ok && cpu_we_i) begin
      wr_en   = 1'b1;
      wr_st   = ST_M;
      wr_data = cpu_wdata_i;
    end
  end

  always_comb begin
    ps_d = ps_q;
    unique case (ps_q)
      PS_IDLE: if (accept) ps_d = local_ok ? PS_RESP : PS_BUS;
      PS_BUS:  if (fill_done) ps_d = PS_RESP;
      default: ps_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q    <= PS_IDLE;
      rdata_q <= '0;
    end else begin
      ps_q <= ps_d;
      if (accept && local_ok)             rdata_q <= cpu_we_i ? cpu_wdata_i : a_data;
      else if (fill_done && !cpu_we_i)    rdata_q <= bus_rdata_i;
      else if (fill_done)                 rdata_q <= cpu_wdata_i;
    end
  end

  assign cpu_ready_o = (ps_q == PS_RESP);
  assign cpu_rdata_o = rdata_q;

  mesi_traffic_counter #(.CNT_W(CNT_W), .CTRL_BYTES(CTRL_BYTES), .LINE_BYTES(LINE_BYTES)) meter_i (
    .clk_i, .rst_ni, .clr_i(cnt_clr_i), .own_valid_i(own_grant), .own_cmd_i(own_cmd),
    .flush_i(flush_o), .count_o(bus_bytes_o)
  );
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cpu_req_i,
  input logic             cpu_ready_o,
  input logic             bus_req_o,
  input logic             bus_gnt_i,
  input logic             snoop_valid_i,
  input logic [1:0]       snoop_cmd_i,
  input logic             snoop_hit_o,
  input logic             snoop_shared_o,
  input logic             supply_o,
  input logic             flush_o,
  input logic             cnt_clr_i,
  input logic [CNT_W-1:0] bus_bytes_o
);
  a_r1_hit_only_on_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_hit_o |-> snoop_valid_i);
  a_r6_shared_on_read_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_shared_o |-> (snoop_hit_o && snoop_cmd_i == 2'd0));
  a_r7_flush_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (snoop_hit_o && snoop_cmd_i[1] == 1'b0));
  a_r8_supply_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_o |-> (snoop_hit_o && snoop_cmd_i[1] == 1'b0));
  a_r10_ready_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> $past(cpu_req_i));
  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> bus_req_o);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (bus_bytes_o == '0));
  a_r9_no_decrease: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_clr_i |=> (bus_bytes_o >= $past(bus_bytes_o)));
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i, .rst_ni, .cpu_req_i, .cpu_ready_o, .bus_req_o, .bus_gnt_i, .snoop_valid_i,
  .snoop_cmd_i, .snoop_hit_o, .snoop_shared_o, .supply_o, .flush_o, .cnt_clr_i, .bus_bytes_o
);

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 16, NC = 4, CW = 12;
  localparam int FULL = 70;
  localparam int SAT = 4095;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_gnt = 0, bus_shared = 0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic [NC-1:0] peer_hit = '0;
  logic snp_hit, snp_shared, supply, flush;
  logic [DW-1:0] snp_data;
  logic cnt_clr = 0;
  logic [CW-1:0] bytes;

  int checks = 0, fails = 0;
  int m_st [4];
  logic [5:0] m_tag [4];
  logic [DW-1:0] m_data [4];
  int m_bytes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETS(4), .NUM_CACHES(NC), .CACHE_ID(1), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_gnt_i(bus_gnt), .bus_rdata_i(bus_rdata), .bus_shared_i(bus_shared),
    .snoop_valid_i(snp_valid), .snoop_cmd_i(snp_cmd), .snoop_addr_i(snp_addr), .peer_hit_i(peer_hit),
    .snoop_hit_o(snp_hit), .snoop_shared_o(snp_shared), .supply_o(supply), .flush_o(flush),
    .snoop_data_o(snp_data), .cnt_clr_i(cnt_clr), .bus_bytes_o(bytes)
  );

  function automatic int sat_bytes(int v);
    return (v > SAT) ? SAT : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_bytes(input string req);
    chk(int'(bytes) == sat_bytes(m_bytes), req, int'(bytes), sat_bytes(m_bytes));
  endtask

  task automatic grant(input logic [DW-1:0] rd, input logic sh);
    bus_gnt = 1; bus_rdata = rd; bus_shared = sh;
    @(negedge clk);
    bus_gnt = 0;
  endtask

  task automatic cpu_op(input logic we, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        input logic [DW-1:0] rd, input logic sh);
    int idx = int'(addr[1:0]);
    logic [5:0] tg = addr[7:2];
    bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    @(negedge clk);
    if (hit && (!we || m_st[idx] >= 2)) begin
      chk(cpu_ready == 1 && bus_req == 0, "R3 local hit", {cpu_ready, bus_req}, 2);
      if (!we) chk(cpu_rdata == m_data[idx], "R3 hit data", int'(cpu_rdata), int'(m_data[idx]));
      else begin m_st[idx] = 3; m_data[idx] = wd; end
    end else begin
      chk(bus_req == 1, "R2 R4 bus request", int'(bus_req), 1);
      if (m_st[idx] == 3 && m_tag[idx] != tg) begin
        chk(bus_cmd == 2 && bus_addr == {m_tag[idx], addr[1:0]} && bus_wdata == m_data[idx],
            "R5 victim write-back", {bus_cmd, bus_addr}, {2'd2, m_tag[idx], addr[1:0]});
        grant('0, 0);
        m_st[idx] = 0; m_bytes += FULL;
      end
      chk(bus_cmd == (we ? 2'd1 : 2'd0) && bus_addr == addr, we ? "R4 ownership read" : "R2 read miss",
          {bus_cmd, bus_addr}, {(we ? 2'd1 : 2'd0), addr});
      grant(rd, sh);
      m_bytes += FULL;
      m_tag[idx] = tg;
      if (we) begin m_st[idx] = 3; m_data[idx] = wd; end
      else begin m_st[idx] = sh ? 1 : 2; m_data[idx] = rd; end
      chk(cpu_ready == 1, "R2 R4 ready after grant", int'(cpu_ready), 1);
      if (!we) chk(cpu_rdata == rd, "R2 fill data", int'(cpu_rdata), int'(rd));
    end
    cpu_req = 0;
    chk_bytes("R9 byte meter");
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] addr, input logic [NC-1:0] peers);
    int idx = int'(addr[1:0]);
    bit hit = (m_st[idx] != 0) && (m_tag[idx] == addr[7:2]);
    bit xfer = (cmd == 0) || (cmd == 1);
    bit e_sup = hit && xfer && !peers[0];
    bit e_fl = hit && xfer && (m_st[idx] == 3);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = addr; peer_hit = peers;
    #1;
    chk(snp_hit == hit, "R6 R7 snoop hit", int'(snp_hit), int'(hit));
    chk(snp_shared == (hit && cmd == 0), "R6 shared line", int'(snp_shared), int'(hit && cmd == 0));
    chk(supply == e_sup, "R8 supplier priority", int'(supply), int'(e_sup));
    chk(flush == e_fl, "R6 R7 flush", int'(flush), int'(e_fl));
    if (e_sup) chk(snp_data == m_data[idx], "R8 supplied data", int'(snp_data), int'(m_data[idx]));
    @(negedge clk);
    snp_valid = 0;
    if (e_fl) m_bytes += FULL;
    if (hit && cmd == 0) m_st[idx] = 1;
    if (hit && (cmd == 1 || cmd == 3)) m_st[idx] = 0;
    chk_bytes("R9 byte meter");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 4; s++) begin m_st[s] = 0; m_tag[s] = '0; m_data[s] = '0; end
    repeat (3) @(negedge clk);
    chk(cpu_ready == 0 && bus_req == 0, "R1 reset outputs", {cpu_ready, bus_req}, 0);
    chk(bytes == 0, "R1 reset meter", int'(bytes), 0);
    rst_n = 1;
    @(negedge clk);
    snoop(2'd0, 8'h04, 4'b0000);  // R1: nothing valid, no hit
    // R2 exclusive fill, R3 silent upgrade
    cpu_op(0, 8'h04, '0, 16'h1111, 0);
    cpu_op(1, 8'h04, 16'h2222, '0, 0);
    cpu_op(0, 8'h04, '0, '0, 0);
    // R6 R8 snooped read on M line
    snoop(2'd0, 8'h04, 4'b0000);
    // R4 write to shared line
    cpu_op(1, 8'h04, 16'h3333, '0, 0);
    // R5 dirty victim then shared fill (R2)
    cpu_op(0, 8'h08, '0, 16'h4444, 1);
    cpu_op(1, 8'h08, 16'h5555, '0, 0);
    // R8 lower-ID peer blocks supply, higher-ID peers ignored
    snoop(2'd0, 8'h08, 4'b0001);
    snoop(2'd0, 8'h08, 4'b1100);
    // R7 peer write-back ignored, peer upgrade invalidates
    snoop(2'd2, 8'h08, 4'b0000);
    cpu_op(0, 8'h08, '0, '0, 0);
    snoop(2'd3, 8'h08, 4'b0000);
    cpu_op(0, 8'h08, '0, 16'h6666, 0);
    // R5 R7 race: victim invalidated by peer while request waits
    cpu_op(1, 8'h01, 16'h7777, '0, 0);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h0D; cpu_wdata = 16'h8888;
    @(negedge clk);
    chk(bus_req == 1 && bus_cmd == 2, "R5 pending write-back", {bus_req, bus_cmd}, 3'b110);
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 8'h01; peer_hit = '0;
    #1;
    chk(flush == 1, "R7 flush while waiting", int'(flush), 1);
    @(negedge clk);
    snp_valid = 0; m_st[1] = 0; m_bytes += FULL;
    chk(bus_req == 1 && bus_cmd == 1 && bus_addr == 8'h0D, "R5 write-back skipped",
        {bus_cmd, bus_addr}, {2'd1, 8'h0D});
    grant('0, 0);
    m_bytes += FULL; m_st[1] = 3; m_tag[1] = 6'h03; m_data[1] = 16'h8888;
    chk(cpu_ready == 1, "R4 ready after race", int'(cpu_ready), 1);
    cpu_req = 0;
    chk_bytes("R9 byte meter");
    // R10 snoop stalls a hit request
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h08;
    snp_valid = 1; snp_cmd = 2'd0; snp_addr = 8'h16; peer_hit = '0;
    @(negedge clk);
    chk(cpu_ready == 0 && bus_req == 0, "R10 request held off", {cpu_ready, bus_req}, 0);
    snp_valid = 0;
    @(negedge clk);
    chk(cpu_ready == 1 && cpu_rdata == 16'h6666, "R10 accepted after snoop", int'(cpu_rdata), 16'h6666);
    cpu_req = 0;
    // R9 clear
    @(negedge clk);
    cnt_clr = 1;
    @(negedge clk);
    cnt_clr = 0; m_bytes = 0;
    chk(bytes == 0, "R9 clear", int'(bytes), 0);
    // random mix, drives meter into saturation
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a = {4'h0, 2'(($urandom % 3)), 2'(($urandom % 4))};
      if (($urandom % 10) < 6)
        cpu_op(1'($urandom % 2), a, 16'($urandom), 16'($urandom), 1'($urandom % 2));
      else
        snoop(2'($urandom % 4), a, 4'($urandom % 16));
    end
    chk(int'(bytes) == SAT, "R9 saturation", int'(bytes), SAT);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule